// File: doc/BRIEF.md
# Audio Frame Timing Generator

This block produces the frame timing for a serial audio port. A bit-clock tick, taken from an internal enable or recovered from an external bit-clock pin, advances a frame bit counter. The counter runs over a programmable frame length of up to 1024 bit clocks. From the counter the block drives a frame-sync pin whose asserted width is programmable. One setting of the width gives a half-frame, left/right style sync. A width of one gives a single-bit pulse of the kind used in DSP-style framing.

As a frame-sync slave the block does not drive the sync pin. It watches an incoming sync, and each active edge of that sync realigns the counter to position zero. Between those edges the counter runs free. An invert control selects whether a frame begins on the rising or the falling edge of the sync. A sampling-edge control chooses which edge of an external bit clock counts as a tick. While both the transmit and receive enables are low, the block idles with its counter at zero. The downstream channel logic reads the current bit position and a frame-start flag.

Top module: `afs_gen`

## Requirements
- R1: While `tx_en` and `rx_en` are both low, after one clock `bit_pos` is 0, `frame_start` is 0, `fs_out` equals `cfg_fs_inv` (the inactive sync level) and `fs_oe` is 0.
- R2: In sync-master mode the first tick after the block is enabled sets `bit_pos` to 0. Each later tick adds one, and a tick at a position greater than or equal to `cfg_frame_len_m1` returns it to 0, so the frame is `cfg_frame_len_m1`+1 bit clocks long (1 to 1024).
- R3: On clock cycles with no tick, `bit_pos`, `frame_start` and `fs_out` keep their values.
- R4: `frame_start` is set by the tick that enters a frame at position 0 and stays high until the next tick, so it is one tick wide and only seen with `bit_pos` = 0.
- R5: After each tick while enabled, `fs_out` = (`bit_pos` < `cfg_sync_len`) XOR `cfg_fs_inv`. A value of half the frame gives 50% duty and a value of 1 gives a one-bit sync.
- R6: With `cfg_fs_inv` = 1, a frame begins on the falling edge of the sync. The driven sync is low during its first `cfg_sync_len` bits, and a sync slave aligns on falling edges of `fs_in`.
- R7: `fs_oe` is 1 exactly when an enable is high and `cfg_fs_slave` = 0.
- R8: With `cfg_fs_slave` = 1, `fs_in` passes through a two-flop synchronizer and is sampled on ticks. After enable the counter waits at 0 with `frame_start` low until a tick sees the active edge. That tick and every later active edge set `bit_pos` to 0 and raise `frame_start`. Between edges the counter runs free and wraps as in R2.
- R9: With `cfg_clk_slave` = 1, ticks come from `bclk_in` after a two-flop synchronizer: rising edges when `cfg_rise_sample` = 1 and falling edges when it is 0. The counter moves on the third clock edge after the pin changes, and `int_tick` has no effect.
- R10: With `cfg_clk_slave` = 0, `int_tick` high in a cycle is a tick at that cycle's clock edge, and `bclk_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| cfg_frame_len_m1 | input | 10 | Frame length minus one, in bit clocks |
| cfg_sync_len | input | 10 | Number of bit clocks the sync is asserted from frame start |
| cfg_fs_inv | input | 1 | 1: frame begins on the falling edge of the sync |
| cfg_fs_slave | input | 1 | 1: take sync from `fs_in` and do not drive `fs_out` |
| cfg_clk_slave | input | 1 | 1: derive ticks from `bclk_in` |
| cfg_rise_sample | input | 1 | 1: rising `bclk_in` edges are ticks, 0: falling edges |
| int_tick | input | 1 | Internal bit-clock enable used in clock-master mode |
| bclk_in | input | 1 | External bit-clock pin (asynchronous) |
| fs_in | input | 1 | External frame-sync pin (asynchronous) |
| bit_pos | output | 10 | Current bit position within the frame |
| frame_start | output | 1 | High for the tick that holds position 0 |
| fs_out | output | 1 | Driven frame-sync level |
| fs_oe | output | 1 | Output enable for the frame-sync pin |

## Verification
An internal tick changes `bit_pos`, `frame_start` and `fs_out` at the same clock edge where `int_tick` is seen. A `bclk_in` or `fs_in` transition first passes two synchronizer flops and an edge register, so it takes effect at the third edge after the pin moves. `fs_oe` follows the enables and mode bits in the same cycle. The bench's reference model steps once per rising edge and carries its own delay line for both pins, so every delay above is built into the expected values. Inputs change just after a rising edge, and all outputs are compared at the falling edge that follows. Each mismatch is tagged with the requirement that owns the output: R3 when no tick fell in that cycle.

// File: rtl/afs_pkg.sv
package afs_pkg;

  localparam int unsigned AFS_SYNC_STAGES = 2;

  typedef struct packed {
    logic fs_inv;
    logic fs_slave;
    logic clk_slave;
    logic rise_sample;
  } afs_mode_t;

endpackage

// File: rtl/afs_sync.sv
module afs_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gs] <= '0;
          else        stage_q[gs] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gs] <= '0;
          else        stage_q[gs] <= stage_q[gs-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/afs_tick.sv
module afs_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  input  logic int_tick,
  input  logic clk_slave,
  input  logic rise_sample,
  output logic tick
);

  logic bclk_prev_q;
  logic ext_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev_q <= 1'b0;
    else        bclk_prev_q <= bclk_s;
  end

  always_comb begin
    if (rise_sample) ext_tick = bclk_s & ~bclk_prev_q;
    else             ext_tick = ~bclk_s & bclk_prev_q;
    tick = clk_slave ? ext_tick : int_tick;
  end

  AST_EXT_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick);                                        // R9

endmodule

// File: rtl/afs_counter.sv
module afs_counter #(
  parameter int unsigned POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             fs_slave,
  input  logic             fs_inv,
  input  logic             fs_s,
  input  logic [POS_W-1:0] flen_m1,
  input  logic [POS_W-1:0] sync_len,
  output logic [POS_W-1:0] pos,
  output logic             fstart,
  output logic             fs_level
);

  logic [POS_W-1:0] pos_q, pos_d, pos_inc;
  logic             st_q, st_d;
  logic             fst_q, fst_d;
  logic             fs_q, fs_d;
  logic             fprev_q, fprev_d;
  logic             edge_hit;

  always_comb begin
    edge_hit = tick && (fs_s != fprev_q) && (fs_s != fs_inv);
    pos_inc  = (pos_q >= flen_m1) ? '0 : pos_q + 1'b1;
    pos_d    = pos_q;
    st_d     = st_q;
    fst_d    = fst_q;
    fs_d     = fs_q;
    fprev_d  = fprev_q;
    if (!run) begin
      pos_d   = '0;
      st_d    = 1'b0;
      fst_d   = 1'b0;
      fs_d    = fs_inv;
      fprev_d = fs_s;
    end else if (tick) begin
      fprev_d = fs_s;
      if (fs_slave) begin
        if (edge_hit) begin
          pos_d = '0;
          st_d  = 1'b1;
        end else if (st_q) begin
          pos_d = pos_inc;
        end else begin
          pos_d = '0;
        end
      end else begin
        pos_d = st_q ? pos_inc : '0;
        st_d  = 1'b1;
      end
      fst_d = st_d && (pos_d == '0);
      fs_d  = (pos_d < sync_len) ^ fs_inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      st_q    <= 1'b0;
      fst_q   <= 1'b0;
      fs_q    <= 1'b0;
      fprev_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      st_q    <= st_d;
      fst_q   <= fst_d;
      fs_q    <= fs_d;
      fprev_q <= fprev_d;
    end
  end

  assign pos      = pos_q;
  assign fstart   = fst_q;
  assign fs_level = fs_q;

  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos_q == '0) && !fst_q);                              // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(pos_q) && $stable(fst_q) && $stable(fs_q)); // R3

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fst_q |-> (pos_q == '0));                                       // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && st_q && (pos_q < flen_m1) && !(fs_slave && edge_hit))
      |=> (pos_q == $past(pos_q) + 1'b1));                          // R2

  AST_SLAVE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fs_slave && edge_hit) |=> (pos_q == '0) && fst_q);      // R8

endmodule

// File: rtl/afs_gen.sv
module afs_gen #(
  parameter int unsigned POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [POS_W-1:0] cfg_frame_len_m1,
  input  logic [POS_W-1:0] cfg_sync_len,
  input  logic             cfg_fs_inv,
  input  logic             cfg_fs_slave,
  input  logic             cfg_clk_slave,
  input  logic             cfg_rise_sample,
  input  logic             int_tick,
  input  logic             bclk_in,
  input  logic             fs_in,
  output logic [POS_W-1:0] bit_pos,
  output logic             frame_start,
  output logic             fs_out,
  output logic             fs_oe
);

  import afs_pkg::*;

  localparam int unsigned PIN_W = 2;

  afs_mode_t  mode;
  logic       run;
  logic       tick;
  logic [PIN_W-1:0] pins_s;

  assign mode = '{fs_inv:      cfg_fs_inv,
                  fs_slave:    cfg_fs_slave,
                  clk_slave:   cfg_clk_slave,
                  rise_sample: cfg_rise_sample};
  assign run  = tx_en | rx_en;

  afs_sync #(.W(PIN_W), .STAGES(AFS_SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fs_in, bclk_in}),
    .q     (pins_s)
  );

  afs_tick u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_s      (pins_s[0]),
    .int_tick    (int_tick),
    .clk_slave   (mode.clk_slave),
    .rise_sample (mode.rise_sample),
    .tick        (tick)
  );

  afs_counter #(.POS_W(POS_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .fs_slave (mode.fs_slave),
    .fs_inv   (mode.fs_inv),
    .fs_s     (pins_s[1]),
    .flen_m1  (cfg_frame_len_m1),
    .sync_len (cfg_sync_len),
    .pos      (bit_pos),
    .fstart   (frame_start),
    .fs_level (fs_out)
  );

  assign fs_oe = run & ~mode.fs_slave;

  AST_IDLE_SYNC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en || rx_en) |=> (fs_out == $past(cfg_fs_inv)));           // R1

endmodule

// File: tb/tb_afs_gen.sv
`timescale 1ns/1ps
module tb_afs_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, rx_en;
  logic [9:0] cfg_frame_len_m1, cfg_sync_len;
  logic       cfg_fs_inv, cfg_fs_slave, cfg_clk_slave, cfg_rise_sample;
  logic       int_tick, bclk_in, fs_in;
  logic [9:0] bit_pos;
  logic       frame_start, fs_out, fs_oe;

  always #2.5 clk = ~clk;

  afs_gen dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .cfg_frame_len_m1(cfg_frame_len_m1), .cfg_sync_len(cfg_sync_len),
    .cfg_fs_inv(cfg_fs_inv), .cfg_fs_slave(cfg_fs_slave),
    .cfg_clk_slave(cfg_clk_slave), .cfg_rise_sample(cfg_rise_sample),
    .int_tick(int_tick), .bclk_in(bclk_in), .fs_in(fs_in),
    .bit_pos(bit_pos), .frame_start(frame_start), .fs_out(fs_out), .fs_oe(fs_oe)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_pos, m_started, m_fstart, m_fs, m_fprev;
  int bq[$];   // bclk pin history, newest at back
  int fq[$];   // fs pin history
  int m_bprev;
  int m_ticked;

  function automatic int qget(ref int q[$], input int age);
    return q[q.size()-1-age];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_started = 0; m_fstart = 0; m_fs = 0; m_fprev = 0;
      m_bprev = 0; m_ticked = 0;
      bq = '{0, 0}; fq = '{0, 0};
    end else begin
      int b_s, f_s, ext, tk, hit, run, nxt, wrap;
      b_s  = qget(bq, 1);
      f_s  = qget(fq, 1);
      ext  = cfg_rise_sample ? (b_s == 1 && m_bprev == 0) : (b_s == 0 && m_bprev == 1);
      tk   = cfg_clk_slave ? ext : int'(int_tick);
      run  = tx_en || rx_en;
      hit  = tk && (f_s != m_fprev) && (f_s != int'(cfg_fs_inv));
      wrap = (m_pos >= int'(cfg_frame_len_m1)) ? 0 : m_pos + 1;
      m_ticked = run && tk;
      if (!run) begin
        m_pos = 0; m_started = 0; m_fstart = 0; m_fs = cfg_fs_inv; m_fprev = f_s;
      end else if (tk) begin
        m_fprev = f_s;
        if (cfg_fs_slave) begin
          if (hit) begin nxt = 0; m_started = 1; end
          else if (m_started) nxt = wrap;
          else nxt = 0;
        end else begin
          nxt = m_started ? wrap : 0;
          m_started = 1;
        end
        m_pos    = nxt;
        m_fstart = m_started && (nxt == 0);
        m_fs     = ((nxt < int'(cfg_sync_len)) ? 1 : 0) ^ int'(cfg_fs_inv);
      end
      m_bprev = b_s;
      bq.push_back(int'(bclk_in)); void'(bq.pop_front());
      fq.push_back(int'(fs_in));   void'(fq.pop_front());
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_ticked ? cur_req : "R3", "bit_pos", int'(bit_pos), m_pos);
      chk(m_ticked ? "R4" : "R3", "frame_start", int'(frame_start), m_fstart);
      chk((tx_en || rx_en) ? (cfg_fs_inv ? "R6" : "R5") : "R1", "fs_out", int'(fs_out), m_fs);
      chk("R7", "fs_oe", int'(fs_oe), ((tx_en || rx_en) && !cfg_fs_slave) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  int lfsr = 32'h1d2c3b4a;
  function automatic int rbit();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr & 1;
  endfunction

  initial begin
    rst_n = 1'b0; tx_en = 0; rx_en = 0;
    cfg_frame_len_m1 = 10'd7; cfg_sync_len = 10'd4;
    cfg_fs_inv = 0; cfg_fs_slave = 0; cfg_clk_slave = 0; cfg_rise_sample = 1;
    int_tick = 0; bclk_in = 0; fs_in = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: idle after reset, with pins and ticks wiggling
    cur_req = "R1";
    for (int i = 0; i < 20; i++) begin int_tick = rbit(); bclk_in = ~bclk_in; step(1); end
    int_tick = 0;
    chk("R1", "idle bit_pos", int'(bit_pos), 0);

    // R2/R5/R10: master, 8-bit frame, half-frame sync, tick every 3 cycles
    cur_req = "R2"; tx_en = 1;
    for (int i = 0; i < 120; i++) begin
      int_tick = (i % 3 == 0); bclk_in = rbit(); step(1);
    end
    int_tick = 0; step(2);

    // R6/R10: receive only, one-bit inverted sync, irregular ticks
    tx_en = 0; rx_en = 1; cur_req = "R10";
    cfg_frame_len_m1 = 10'd5; cfg_sync_len = 10'd1; cfg_fs_inv = 1;
    for (int i = 0; i < 150; i++) begin int_tick = rbit(); bclk_in = rbit(); step(1); end
    int_tick = 0;

    // R1: disable mid-frame
    rx_en = 0; cur_req = "R1";
    for (int i = 0; i < 10; i++) begin int_tick = 1; step(1); end
    int_tick = 0;
    chk("R1", "fs_out idle level", int'(fs_out), 1);

    // R9: clock slave, rising then falling sampling, int_tick noise ignored
    cfg_fs_inv = 0; cfg_clk_slave = 1; cfg_rise_sample = 1; tx_en = 1;
    cfg_frame_len_m1 = 10'd9; cfg_sync_len = 10'd5; cur_req = "R9";
    for (int i = 0; i < 200; i++) begin
      if (i % 2 == 0) bclk_in = ~bclk_in;
      int_tick = rbit(); step(1);
    end
    cfg_rise_sample = 0;
    for (int i = 0; i < 200; i++) begin
      if (i % 3 == 0) bclk_in = ~bclk_in;
      int_tick = rbit(); step(1);
    end
    tx_en = 0; int_tick = 0; step(3);

    // R8: sync slave, 16-tick frames on fs_in, then a short frame to realign
    cfg_clk_slave = 0; cfg_fs_slave = 1; cfg_frame_len_m1 = 10'd15;
    cfg_sync_len = 10'd8; cur_req = "R8"; fs_in = 0;
    tx_en = 1; step(5);
    for (int f = 0; f < 6; f++) begin
      int flen = (f == 3) ? 12 : 16;
      for (int t = 0; t < flen; t++) begin
        fs_in = (t < flen / 2);
        int_tick = 0; step(1);
        int_tick = 1; step(1);
      end
    end
    int_tick = 0; tx_en = 0; step(3);

    // R6/R8: slave with inverted sync (falling edge starts frame)
    cfg_fs_inv = 1; fs_in = 1; rx_en = 1; cur_req = "R6"; step(4);
    for (int f = 0; f < 5; f++) begin
      for (int t = 0; t < 10; t++) begin
        fs_in = !(t < 5);
        int_tick = 0; step(1);
        int_tick = 1; step(1);
      end
    end
    int_tick = 0; rx_en = 0; step(3);

    // R2: longest frame (1024 bits), tick every cycle
    cfg_fs_slave = 0; cfg_fs_inv = 0; cfg_frame_len_m1 = 10'd1023;
    cfg_sync_len = 10'd512; cur_req = "R2"; tx_en = 1; int_tick = 1;
    step(1024);
    chk("R2", "last position of max frame", int'(bit_pos), 1023);
    step(1);
    chk("R2", "wrap to zero", int'(bit_pos), 0);
    chk("R4", "frame_start at wrap", int'(frame_start), 1);
    step(1030);
    int_tick = 0; tx_en = 0; step(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule